// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out one combined modify-test-branch step for a counted loop. A single control byte picks the operation and the register. The operation is decrement by one, increment by one, or test with no change. The control byte also picks the branch sense and the sign of the branch offset. The block reads the chosen register through a read port. It computes the adjusted value, writes that value back through a write port, and decides whether the loop branch is taken. It also produces the next program counter.

The caller presents the control byte, the low offset byte and the program counter on the same cycle as a one-cycle `start`. The program counter must already point past the offset byte. The register file sits outside the block and must return `rd_data` combinationally from `rd_sel`. One clock later the block drives a one-cycle `valid` strobe. In that same cycle it drives the branch decision, the next program counter, the error flag and the write-back request. The register file commits the write at the following edge.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `valid`, `wr_en`, `err` and `taken` are 0.
- R2: Control byte bits 7:6 choose the operation. The value 00 subtracts one from the register, 10 adds one, and 01 leaves it unchanged and only tests it.
- R3: The control byte value 11 in bits 7:6 is invalid. It gives `err`=1 with `valid`, no write (`wr_en`=0), `taken`=0 and `pc_out` equal to the presented program counter.
- R4: Control byte bit 4 is the sign and `offset` holds the low eight bits of a 9-bit two's-complement displacement. The taken target is the 16-bit sum of the presented program counter and this displacement, sign-extended and wrapping modulo 2^16.
- R5: Control byte bit 5 sets the branch sense. With 1 the branch is taken when the adjusted value is nonzero. With 0 it is taken when the adjusted value is zero.
- R6: Control byte bits 2:0 select the register and appear on `rd_sel` in the same cycle. Codes 0 to 3 select the 8-bit registers: 0 is accumulator A, 1 is accumulator B, 2 is the condition register and 3 is the scratch register. Codes 4 to 7 select the 16-bit registers: 4 is D, 5 is X, 6 is Y and 7 is SP. Bit 3 is ignored.
- R7: For every valid operation the adjusted value is written back to the selected register (`wr_en`=1, `wr_sel` = code), whether or not the branch is taken.
- R8: For codes 0 to 3 only the low byte of `rd_data` is adjusted and tested. The byte wraps modulo 256, and `wr_data[15:8]` is 0.
- R9: `valid` is high exactly in the cycle after `start`. When the branch is not taken, `pc_out` equals the presented program counter.
- R10: For codes 4 to 7 the full 16-bit value is adjusted and tested, wrapping modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; operands sampled at this edge |
| ctrl | input | 8 | Control byte (operation, sense, sign, register) |
| offset | input | 8 | Low eight bits of the branch displacement |
| pc_in | input | 16 | Program counter, already past the offset byte |
| rd_sel | output | 3 | Register read select |
| rd_data | input | 16 | Register read data, combinational from `rd_sel` |
| wr_en | output | 1 | Register write request |
| wr_sel | output | 3 | Register write select |
| wr_data | output | 16 | Register write data |
| valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| pc_out | output | 16 | Next program counter |
| err | output | 1 | Invalid operation code |

## Verification
The assertions assume that `start` is never held on two cycles in a row. They also assume that `rd_data` reflects `rd_sel` within the cycle, so that the value captured at the `start` edge belongs to the selected register. The stimulus drives `start` for a single cycle and then leaves at least two idle cycles before the next request. This lets the previous write-back land in the bench's register model before the next read. Register preloads deliberately put nonzero data in the upper byte of the 8-bit registers. This shows that only the low byte takes part in the adjustment.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        OP_DEC = 2'b00,
        OP_TST = 2'b01,
        OP_INC = 2'b10,
        OP_BAD = 2'b11
    } loop_op_e;

    typedef struct packed {
        loop_op_e         op;
        logic             on_nonzero;
        logic             off_neg;
        logic [SEL_W-1:0] sel;
    } loop_ctrl_t;

    function automatic logic sel_is_byte(input logic [SEL_W-1:0] sel);
        return !sel[SEL_W-1];
    endfunction
endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
    import lcb_pkg::*;
(
    input  logic [7:0]  ctrl,
    output loop_ctrl_t  dec
);
    always_comb begin
        dec.op         = loop_op_e'(ctrl[7:6]);
        dec.on_nonzero = ctrl[5];
        dec.off_neg    = ctrl[4];
        dec.sel        = ctrl[SEL_W-1:0];
    end
endmodule

// File: rtl/lcb_adjust.sv
module lcb_adjust
    import lcb_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W
) (
    input  loop_op_e      op,
    input  logic          byte_mode,
    input  logic [W-1:0]  value,
    output logic [W-1:0]  result,
    output logic          is_zero
);
    logic [W-1:0] delta;
    logic [W-1:0] sum;

    always_comb begin
        unique case (op)
            OP_DEC:  delta = '1;
            OP_INC:  delta = W'(1);
            default: delta = '0;
        endcase
        sum = value + delta;
        if (byte_mode) begin
            result  = {{(W-BW){1'b0}}, sum[BW-1:0]};
            is_zero = (sum[BW-1:0] == '0);
        end else begin
            result  = sum;
            is_zero = (sum == '0);
        end
    end
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
    parameter int AW = 16,
    parameter int OW = 8
) (
    input  logic          neg,
    input  logic [OW-1:0] off,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] target
);
    localparam int EXT_W = AW - OW;
    logic [AW-1:0] disp;

    always_comb begin
        disp   = {{EXT_W{neg}}, off};
        target = pc + disp;
    end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lcb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [7:0]          ctrl,
    input  logic [BYTE_W-1:0]   offset,
    input  logic [ADDR_W-1:0]   pc_in,
    output logic [SEL_W-1:0]    rd_sel,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                wr_en,
    output logic [SEL_W-1:0]    wr_sel,
    output logic [DATA_W-1:0]   wr_data,
    output logic                valid,
    output logic                taken,
    output logic [ADDR_W-1:0]   pc_out,
    output logic                err
);
    loop_ctrl_t          dec;
    logic [DATA_W-1:0]   adj_val;
    logic                adj_zero;
    logic [ADDR_W-1:0]   tgt;
    logic                bad_op;
    logic                take_n;

    lcb_decode u_dec (
        .ctrl (ctrl),
        .dec  (dec)
    );

    lcb_adjust #(.W(DATA_W), .BW(BYTE_W)) u_adj (
        .op        (dec.op),
        .byte_mode (sel_is_byte(dec.sel)),
        .value     (rd_data),
        .result    (adj_val),
        .is_zero   (adj_zero)
    );

    lcb_target #(.AW(ADDR_W), .OW(BYTE_W)) u_tgt (
        .neg    (dec.off_neg),
        .off    (offset),
        .pc     (pc_in),
        .target (tgt)
    );

    assign rd_sel = dec.sel;

    always_comb begin
        bad_op = (dec.op == OP_BAD);
        take_n = !bad_op && (dec.on_nonzero ? !adj_zero : adj_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            wr_en   <= 1'b0;
            err     <= 1'b0;
            taken   <= 1'b0;
            wr_sel  <= '0;
            wr_data <= '0;
            pc_out  <= '0;
        end else begin
            valid   <= start;
            wr_en   <= start && !bad_op;
            err     <= start && bad_op;
            taken   <= start && take_n;
            if (start) begin
                wr_sel  <= dec.sel;
                wr_data <= adj_val;
                pc_out  <= take_n ? tgt : pc_in;
            end
        end
    end

    // Outputs held quiet through and just after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!valid && !wr_en && !err && !taken));

    assert_valid_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(start));

    assert_untaken_keeps_pc_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && !taken) |-> (pc_out == $past(pc_in)));

    assert_bad_op_flag_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (err == ($past(ctrl[7:6]) == 2'b11)));

    assert_bad_op_inert_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && err) |-> (!taken && !wr_en));

    assert_writeback_always_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !err) |-> (wr_en && wr_sel == $past(ctrl[2:0])));

    assert_byte_upper_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel[SEL_W-1]) |-> (wr_data[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/tb_loop_branch_unit.sv
module tb_loop_branch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  ctrl = 8'h00;
    logic [7:0]  offset = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        valid;
    logic        taken;
    logic [15:0] pc_out;
    logic        err;

    int checks = 0;
    int errors = 0;
    logic [15:0] rf [8];

    always #10 clk = ~clk;

    loop_branch_unit dut (
        .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .offset(offset),
        .pc_in(pc_in), .rd_sel(rd_sel), .rd_data(rd_data), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .valid(valid), .taken(taken),
        .pc_out(pc_out), .err(err)
    );

    assign rd_data = rf[rd_sel];
    always @(posedge clk) if (wr_en) rf[wr_sel] <= wr_data;

    typedef struct packed {
        logic [7:0]  cb;
        logic [7:0]  off;
        logic [15:0] pc;
        logic [15:0] init;
        logic        exp_taken;
        logic [15:0] exp_pc;
        logic [15:0] exp_wd;
        logic        exp_err;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'h05, 8'h10, 16'h1000, 16'h0001, 1'b1, 16'h1010, 16'h0000, 1'b0, 8'd2},
        '{8'h35, 8'hF0, 16'h2000, 16'h0005, 1'b1, 16'h1FF0, 16'h0004, 1'b0, 8'd4},
        '{8'h86, 8'h7F, 16'h3000, 16'hFFFF, 1'b1, 16'h307F, 16'h0000, 1'b0, 8'd10},
        '{8'hA4, 8'h22, 16'h4000, 16'hFFFF, 1'b0, 16'h4000, 16'h0000, 1'b0, 8'd5},
        '{8'h57, 8'h00, 16'h0080, 16'h0000, 1'b1, 16'hFF80, 16'h0000, 1'b0, 8'd4},
        '{8'h61, 8'h40, 16'h5555, 16'h0000, 1'b0, 16'h5555, 16'h0000, 1'b0, 8'd5},
        '{8'h20, 8'h05, 16'h6000, 16'hAB00, 1'b1, 16'h6005, 16'h00FF, 1'b0, 8'd8},
        '{8'h92, 8'h80, 16'h0100, 16'h12FF, 1'b1, 16'h0080, 16'h0000, 1'b0, 8'd8},
        '{8'h0B, 8'h01, 16'h7000, 16'h0002, 1'b0, 16'h7000, 16'h0001, 1'b0, 8'd6},
        '{8'hE5, 8'h10, 16'h8000, 16'h1234, 1'b0, 16'h8000, 16'h1234, 1'b1, 8'd3},
        '{8'h25, 8'h01, 16'h9000, 16'h0000, 1'b1, 16'h9001, 16'hFFFF, 1'b0, 8'd10}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) rf[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet during reset
        check("R1 valid", {15'd0, valid}, 16'd0);
        check("R1 wr_en", {15'd0, wr_en}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 err/taken", {14'd0, err, taken}, 16'd0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] s;
            s = VEC[v].cb[2:0];
            rf[s] = VEC[v].init;
            ctrl = VEC[v].cb; offset = VEC[v].off; pc_in = VEC[v].pc;
            start = 1'b1;
            #1;
            // R6: read select follows control byte within the cycle
            check("R6 rd_sel", {13'd0, rd_sel}, {13'd0, s});
            @(negedge clk);
            start = 1'b0;
            $display("vector %0d (R%0d)", v, VEC[v].tag);
            check("R9 valid", {15'd0, valid}, 16'd1);
            check("R5 taken", {15'd0, taken}, {15'd0, VEC[v].exp_taken});
            check("R4 pc_out", pc_out, VEC[v].exp_pc);
            check("R3 err", {15'd0, err}, {15'd0, VEC[v].exp_err});
            check("R7 wr_en", {15'd0, wr_en}, {15'd0, ~VEC[v].exp_err});
            if (!VEC[v].exp_err) begin
                check("R2 wr_data", wr_data, VEC[v].exp_wd);
                check("R7 wr_sel", {13'd0, wr_sel}, {13'd0, s});
            end
            @(negedge clk);
            check("R9 valid pulse", {15'd0, valid}, 16'd0);
            // R8 R10 R3: register model after write-back
            check("R8 regfile", rf[s], VEC[v].exp_wd);
            @(negedge clk);
        end

        // R2: test mode leaves a nonzero 16-bit register unchanged
        rf[6] = 16'h00C3;
        ctrl = 8'h66; offset = 8'h02; pc_in = 16'hA000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 test keeps value", wr_data, 16'h00C3);
        check("R5 nonzero taken", pc_out, 16'hA002);
        @(negedge clk);
        check("R2 regfile kept", rf[6], 16'h00C3);

        // R1: reset mid-stream clears result strobe
        @(negedge clk);
        ctrl = 8'h05; rf[5] = 16'h0001; start = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 reset over start", {15'd0, valid}, 16'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule